// File: doc/BRIEF.md
# Audio Function Configuration Register Bank

This block holds the type-0 configuration header of an audio function. It also holds a power-management capability and a small group of vendor control registers for the legacy audio engines and the codec link. Host-side logic that has already decoded a configuration transaction presents a dword index, write data, four byte lanes and one strobe. The bank then either updates its registers at the next clock edge or returns the addressed dword in the same cycle.

The identity fields are constants set by parameters. The status register has two sticky error flags. A detected address parity error sets them, and software clears them by writing ones. A command-register enable decides whether that error is signalled on the active-low system error output. Four live values are exposed as outputs: the power-state field, the codec reset control, and the two legacy control words. Other logic uses them to gate clocks and to configure the legacy engines. The power-state field never takes the unsupported D1 value.

Top module: `audCfgTop`

## Requirements
- R1: Dword 00h reads 000C1073h (device ID in the upper half, vendor ID 1073h in the lower half), and dword 2Ch reads 000C1073h (subsystem vendor ID 1073h in the lower half). Writes to either dword change nothing.
- R2: Dword 08h reads 04010003h (revision ID 03h in byte 0), and the header-type byte at 0Eh reads 00h.
- R3: A write updates only the byte lanes whose enable bit is set (bit n covers data bits 8n+7..8n). The latency timer (byte 1 of dword 0Ch) and the interrupt line (byte 0 of dword 3Ch) reset to 00h and are writable. The interrupt pin (byte 1 of dword 3Ch) always reads 01h.
- R4: The status half of dword 04h (bits 31:16) resets to 0210h. An address parity error sets status bit 15. It also sets status bit 14 when the system error output is enabled. Writing one to either bit clears it, and writing zero leaves it unchanged. When a set and a clear fall in the same cycle, the set wins.
- R5: The command half of dword 04h keeps only bits 0, 1, 2, 6 and 8, resets to 0000h, and reads zero in every other bit. When command bit 8 is set and addrParErr is sampled high at an edge, serrN is low for exactly the following cycle. When bit 8 is clear, serrN stays high.
- R6: The capability pointer (byte 0 of dword 34h) reads 50h. Dword 50h reads 04010001h: capability ID 01h, next pointer 00h, and capability bits 0401h.
- R7: Bits 1:0 of dword 54h hold the power state and reset to 0 (D0). A byte-0 write of 0, 2 or 3 appears on pwrState at the next edge. A write of 1 (D1) is ignored and the previous state is kept.
- R8: Dword 40h resets to 0000907Fh (legacy control 907Fh in the low half, extended legacy control 0000h in the high half). All 32 bits are writable, and the two halves drive legacyCtl and legacyExt.
- R9: Bit 0 of dword 48h resets to 1 and is the only writable bit there. When it is 1, codecRstN is low; when it is 0, codecRstN is high.
- R10: Unimplemented dword indices read zero and discard writes. cfgRdata is zero whenever cfgRd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgAddr | input | 6 | Dword index of the configuration access |
| cfgWdata | input | 32 | Write data |
| cfgBe | input | 4 | Byte-lane enables |
| cfgWr | input | 1 | Write strobe |
| cfgRd | input | 1 | Read strobe |
| addrParErr | input | 1 | Address parity error detected on a target cycle |
| cfgRdata | output | 32 | Read data, valid in the cycle of cfgRd |
| serrN | output | 1 | Active-low system error |
| codecRstN | output | 1 | Active-low codec reset |
| pwrState | output | 2 | Current power state (0, 2 or 3) |
| legacyCtl | output | 16 | Legacy audio control word |
| legacyExt | output | 16 | Extended legacy audio control word |

## Verification
Read data is combinational, so each read is sampled one time unit after the strobe is raised, in the same cycle. A register write lands at the clock edge where the strobe is high. The bench therefore drives every access at a falling edge and checks it at a later falling edge, after one rising edge has passed. A parity error held high across one rising edge drives serrN low for the next cycle only. The bench checks serrN at the falling edge right after that rising edge, and again one cycle later to confirm it has returned high. The set-versus-clear race is driven in a single cycle, with both the parity error and the clearing write present at the same edge.

// File: rtl/audCfgPkg.sv
package audCfgPkg;

  localparam int DW_ID     = 0;
  localparam int DW_CMD    = 1;
  localparam int DW_CLASS  = 2;
  localparam int DW_LAT    = 3;
  localparam int DW_SUBSYS = 11;
  localparam int DW_CAPPTR = 13;
  localparam int DW_INT    = 15;
  localparam int DW_LEGACY = 16;
  localparam int DW_CTL    = 18;
  localparam int DW_CAP    = 20;
  localparam int DW_PM     = 21;

  localparam int NUM_SEL   = 11;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [3:0] be;
    logic       selId;
    logic       selCmd;
    logic       selClass;
    logic       selLat;
    logic       selSubsys;
    logic       selCapPtr;
    logic       selInt;
    logic       selLegacy;
    logic       selCtl;
    logic       selCap;
    logic       selPm;
  } cfgStrobe_t;

endpackage

// File: rtl/audCfgDecode.sv
module audCfgDecode
  import audCfgPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [3:0]        cfgBe,
  input  logic              cfgWr,
  input  logic              cfgRd,
  output cfgStrobe_t        stb
);

  logic [NUM_SEL-1:0] selVec;

  always_comb begin
    stb           = '0;
    stb.wr        = cfgWr;
    stb.rd        = cfgRd;
    stb.be        = cfgBe;
    stb.selId     = (cfgAddr == ADDR_W'(DW_ID));
    stb.selCmd    = (cfgAddr == ADDR_W'(DW_CMD));
    stb.selClass  = (cfgAddr == ADDR_W'(DW_CLASS));
    stb.selLat    = (cfgAddr == ADDR_W'(DW_LAT));
    stb.selSubsys = (cfgAddr == ADDR_W'(DW_SUBSYS));
    stb.selCapPtr = (cfgAddr == ADDR_W'(DW_CAPPTR));
    stb.selInt    = (cfgAddr == ADDR_W'(DW_INT));
    stb.selLegacy = (cfgAddr == ADDR_W'(DW_LEGACY));
    stb.selCtl    = (cfgAddr == ADDR_W'(DW_CTL));
    stb.selCap    = (cfgAddr == ADDR_W'(DW_CAP));
    stb.selPm     = (cfgAddr == ADDR_W'(DW_PM));
  end

  assign selVec = {stb.selId, stb.selCmd, stb.selClass, stb.selLat, stb.selSubsys,
                   stb.selCapPtr, stb.selInt, stb.selLegacy, stb.selCtl, stb.selCap,
                   stb.selPm};

  // R10: at most one register decoded per access
  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selVec));

endmodule

// File: rtl/audCfgRegs.sv
module audCfgRegs
  import audCfgPkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1073,
  parameter logic [15:0] DEVICE_ID  = 16'h000C,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h040100,
  parameter logic [15:0] SUBSYS_ID  = 16'h000C,
  parameter logic [7:0]  CAP_OFFSET = 8'h50,
  parameter logic [15:0] PM_CAPS    = 16'h0401,
  parameter logic [15:0] LEG_RST    = 16'h907F,
  parameter logic [15:0] LEGX_RST   = 16'h0000,
  parameter logic [15:0] CMD_WMASK  = 16'h0147
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobe_t  stb,
  input  logic [31:0] cfgWdata,
  input  logic        addrParErr,
  output logic [31:0] cfgRdata,
  output logic        serrN,
  output logic        codecRstN,
  output logic [1:0]  pwrState,
  output logic [15:0] legacyCtl,
  output logic [15:0] legacyExt
);

  localparam int NBYTES = 4;
  localparam logic [1:0] PS_D1 = 2'd1;

  logic [15:0] cmdReg;
  logic        stsDpe;
  logic        stsSse;
  logic [7:0]  latTmr;
  logic [7:0]  intLine;
  logic [31:0] legReg;
  logic        codecRst;
  logic [1:0]  pmState;
  logic        serrNQ;

  logic        serrEn;
  logic        wrCmd;
  logic        clrDpe;
  logic        clrSse;
  logic        setSse;
  logic [15:0] stsWord;

  assign serrEn = cmdReg[8];
  assign wrCmd  = stb.wr && stb.selCmd;
  assign clrDpe = wrCmd && stb.be[3] && cfgWdata[31];
  assign clrSse = wrCmd && stb.be[3] && cfgWdata[30];
  assign setSse = addrParErr && serrEn;

  assign stsWord = {stsDpe, stsSse, 4'b0000, 1'b1, 4'b0000, 1'b1, 4'b0000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      stsDpe   <= 1'b0;
      stsSse   <= 1'b0;
      latTmr   <= '0;
      intLine  <= '0;
      legReg   <= {LEGX_RST, LEG_RST};
      codecRst <= 1'b1;
      pmState  <= 2'd0;
      serrNQ   <= 1'b1;
    end else begin
      if (wrCmd && stb.be[0]) cmdReg[7:0]  <= cfgWdata[7:0]  & CMD_WMASK[7:0];
      if (wrCmd && stb.be[1]) cmdReg[15:8] <= cfgWdata[15:8] & CMD_WMASK[15:8];

      if (addrParErr)  stsDpe <= 1'b1;
      else if (clrDpe) stsDpe <= 1'b0;
      if (setSse)      stsSse <= 1'b1;
      else if (clrSse) stsSse <= 1'b0;

      serrNQ <= !setSse;

      if (stb.wr && stb.selLat && stb.be[1]) latTmr  <= cfgWdata[15:8];
      if (stb.wr && stb.selInt && stb.be[0]) intLine <= cfgWdata[7:0];

      for (int b = 0; b < NBYTES; b++) begin
        if (stb.wr && stb.selLegacy && stb.be[b]) legReg[8*b +: 8] <= cfgWdata[8*b +: 8];
      end

      if (stb.wr && stb.selCtl && stb.be[0]) codecRst <= cfgWdata[0];

      if (stb.wr && stb.selPm && stb.be[0] && (cfgWdata[1:0] != PS_D1))
        pmState <= cfgWdata[1:0];
    end
  end

  always_comb begin
    cfgRdata = '0;
    if (stb.rd) begin
      if (stb.selId)     cfgRdata = {DEVICE_ID, VENDOR_ID};
      if (stb.selCmd)    cfgRdata = {stsWord, cmdReg};
      if (stb.selClass)  cfgRdata = {CLASS_CODE, REV_ID};
      if (stb.selLat)    cfgRdata = {8'h00, 8'h00, latTmr, 8'h00};
      if (stb.selSubsys) cfgRdata = {SUBSYS_ID, VENDOR_ID};
      if (stb.selCapPtr) cfgRdata = {24'h0, CAP_OFFSET};
      if (stb.selInt)    cfgRdata = {16'h0, 8'h01, intLine};
      if (stb.selLegacy) cfgRdata = legReg;
      if (stb.selCtl)    cfgRdata = {31'h0, codecRst};
      if (stb.selCap)    cfgRdata = {PM_CAPS, 8'h00, 8'h01};
      if (stb.selPm)     cfgRdata = {30'h0, pmState};
    end
  end

  assign serrN     = serrNQ;
  assign codecRstN = !codecRst;
  assign pwrState  = pmState;
  assign legacyCtl = legReg[15:0];
  assign legacyExt = legReg[31:16];

  // R7: the power state never holds D1
  p_no_d1_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    pmState != PS_D1);

  // R7: a D1 request leaves the state untouched
  p_d1_write_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && stb.selPm && stb.be[0] && cfgWdata[1:0] == PS_D1) |=> $stable(pmState));

  // R5: no system error while the enable bit is clear
  p_serr_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (addrParErr && !serrEn) |=> serrN);

  // R4: a parity error always leaves the detected flag set
  p_dpe_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    addrParErr |=> stsDpe);

  // R4: writing one clears the flag when no new error arrives
  p_dpe_w1c_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clrDpe && !addrParErr) |=> !stsDpe);

endmodule

// File: rtl/audCfgTop.sv
module audCfgTop
  import audCfgPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic [3:0]        cfgBe,
  input  logic              cfgWr,
  input  logic              cfgRd,
  input  logic              addrParErr,
  output logic [31:0]       cfgRdata,
  output logic              serrN,
  output logic              codecRstN,
  output logic [1:0]        pwrState,
  output logic [15:0]       legacyCtl,
  output logic [15:0]       legacyExt
);

  cfgStrobe_t stb;

  audCfgDecode #(.ADDR_W(ADDR_W)) uDecode (
    .clk     (clk),
    .rstN    (rstN),
    .cfgAddr (cfgAddr),
    .cfgBe   (cfgBe),
    .cfgWr   (cfgWr),
    .cfgRd   (cfgRd),
    .stb     (stb)
  );

  audCfgRegs uRegs (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgWdata   (cfgWdata),
    .addrParErr (addrParErr),
    .cfgRdata   (cfgRdata),
    .serrN      (serrN),
    .codecRstN  (codecRstN),
    .pwrState   (pwrState),
    .legacyCtl  (legacyCtl),
    .legacyExt  (legacyExt)
  );

endmodule

// File: tb/tb_audCfgTop.sv
`timescale 1ns/1ps
module tb_audCfgTop;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [3:0]  cfgBe = '0;
  logic        cfgWr = 1'b0;
  logic        cfgRd = 1'b0;
  logic        addrParErr = 1'b0;
  logic [31:0] cfgRdata;
  logic        serrN;
  logic        codecRstN;
  logic [1:0]  pwrState;
  logic [15:0] legacyCtl;
  logic [15:0] legacyExt;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  audCfgTop dut (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgBe(cfgBe),
    .cfgWr(cfgWr), .cfgRd(cfgRd), .addrParErr(addrParErr), .cfgRdata(cfgRdata),
    .serrN(serrN), .codecRstN(codecRstN), .pwrState(pwrState),
    .legacyCtl(legacyCtl), .legacyExt(legacyExt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgAddr = a; cfgWdata = d; cfgBe = be; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0; cfgBe = '0;
  endtask

  task automatic doRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgRd = 1'b1;
    #1 d = cfgRdata;
    cfgRd = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    doRead(a, v);
    check(tag, v, exp);
  endtask

  task automatic testReset();
    readCheck("R1 id dword", 6'h00, 32'h000C1073);
    readCheck("R1 subsystem dword", 6'h0B, 32'h000C1073);
    readCheck("R2 class/revision", 6'h02, 32'h04010003);
    readCheck("R2 header/latency dword", 6'h03, 32'h00000000);
    readCheck("R3 interrupt dword", 6'h0F, 32'h00000100);
    readCheck("R4 status/command", 6'h01, 32'h02100000);
    readCheck("R6 cap pointer", 6'h0D, 32'h00000050);
    readCheck("R6 cap dword", 6'h14, 32'h04010001);
    readCheck("R7 pm dword", 6'h15, 32'h00000000);
    readCheck("R8 legacy dword", 6'h10, 32'h0000907F);
    readCheck("R9 control dword", 6'h12, 32'h00000001);
    check("R9 codecRstN at reset", {31'h0, codecRstN}, 32'h0);
    check("R5 serrN at reset", {31'h0, serrN}, 32'h1);
    check("R7 pwrState at reset", {30'h0, pwrState}, 32'h0);
  endtask

  task automatic testReadOnly();
    doWrite(6'h00, 32'hFFFFFFFF, 4'hF);
    doWrite(6'h0B, 32'hFFFFFFFF, 4'hF);
    doWrite(6'h02, 32'hFFFFFFFF, 4'hF);
    doWrite(6'h14, 32'hFFFFFFFF, 4'hF);
    readCheck("R1 id after write", 6'h00, 32'h000C1073);
    readCheck("R1 subsystem after write", 6'h0B, 32'h000C1073);
    readCheck("R2 class after write", 6'h02, 32'h04010003);
    readCheck("R6 cap after write", 6'h14, 32'h04010001);
  endtask

  task automatic testBytes();
    doWrite(6'h0F, 32'hAABBCCDD, 4'b0001);
    readCheck("R3 interrupt line byte", 6'h0F, 32'h000001DD);
    doWrite(6'h03, 32'h12345678, 4'b0010);
    readCheck("R3 latency byte", 6'h03, 32'h00005600);
    doWrite(6'h10, 32'h11223344, 4'b0100);
    readCheck("R8 legacy single byte", 6'h10, 32'h0022907F);
    doWrite(6'h10, 32'hDEADBEEF, 4'b1111);
    readCheck("R8 legacy full", 6'h10, 32'hDEADBEEF);
    check("R8 legacyCtl out", {16'h0, legacyCtl}, 32'h0000BEEF);
    check("R8 legacyExt out", {16'h0, legacyExt}, 32'h0000DEAD);
  endtask

  task automatic pulseParity(input logic expLow, input string tag);
    @(negedge clk);
    addrParErr = 1'b1;
    @(negedge clk);
    addrParErr = 1'b0;
    check({tag, " first cycle"}, {31'h0, serrN}, {31'h0, !expLow});
    @(negedge clk);
    check({tag, " second cycle"}, {31'h0, serrN}, 32'h1);
  endtask

  task automatic testStatus();
    doWrite(6'h01, 32'hFFFFFFFF, 4'b0011);
    readCheck("R5 command mask", 6'h01, 32'h02100147);
    pulseParity(1'b1, "R5 serr enabled");
    readCheck("R4 both flags set", 6'h01, 32'hC2100147);
    doWrite(6'h01, 32'h00000000, 4'b1000);
    readCheck("R4 zero write keeps flags", 6'h01, 32'hC2100147);
    doWrite(6'h01, 32'h80000000, 4'b1000);
    readCheck("R4 clear bit15", 6'h01, 32'h42100147);
    doWrite(6'h01, 32'h40000000, 4'b1000);
    readCheck("R4 clear bit14", 6'h01, 32'h02100147);
    doWrite(6'h01, 32'h00000000, 4'b0010);
    readCheck("R5 bit8 cleared", 6'h01, 32'h02100047);
    pulseParity(1'b0, "R5 serr disabled");
    readCheck("R4 only bit15 set", 6'h01, 32'h82100047);
    doWrite(6'h01, 32'hC0000000, 4'b1000);
    readCheck("R4 clear both", 6'h01, 32'h02100047);
    // R4: set and clear in the same cycle
    @(negedge clk);
    cfgAddr = 6'h01; cfgWdata = 32'h80000000; cfgBe = 4'b1000; cfgWr = 1'b1; addrParErr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0; cfgBe = '0; addrParErr = 1'b0;
    readCheck("R4 set wins over clear", 6'h01, 32'h82100047);
  endtask

  task automatic testPower();
    doWrite(6'h15, 32'h00000003, 4'b0001);
    check("R7 D3 taken", {30'h0, pwrState}, 32'h3);
    doWrite(6'h15, 32'h00000001, 4'b0001);
    check("R7 D1 ignored", {30'h0, pwrState}, 32'h3);
    readCheck("R7 D1 ignored readback", 6'h15, 32'h00000003);
    doWrite(6'h15, 32'h00000002, 4'b0001);
    check("R7 D2 taken", {30'h0, pwrState}, 32'h2);
    doWrite(6'h15, 32'h00000000, 4'b0010);
    check("R7 byte0 disabled", {30'h0, pwrState}, 32'h2);
    doWrite(6'h15, 32'h00000000, 4'b0001);
    check("R7 D0 taken", {30'h0, pwrState}, 32'h0);
  endtask

  task automatic testCodec();
    doWrite(6'h12, 32'h00000000, 4'b0001);
    check("R9 codec released", {31'h0, codecRstN}, 32'h1);
    readCheck("R9 control cleared", 6'h12, 32'h00000000);
    doWrite(6'h12, 32'hFFFFFFFF, 4'b1111);
    readCheck("R9 only bit0 kept", 6'h12, 32'h00000001);
    check("R9 codec in reset", {31'h0, codecRstN}, 32'h0);
  endtask

  task automatic testUnimpl();
    doWrite(6'h30, 32'hFFFFFFFF, 4'hF);
    readCheck("R10 unimplemented after write", 6'h30, 32'h00000000);
    readCheck("R10 top dword", 6'h3F, 32'h00000000);
    @(negedge clk);
    cfgAddr = 6'h00; cfgRd = 1'b0;
    #1 check("R10 no read strobe", cfgRdata, 32'h00000000);
    readCheck("R10 legacy unchanged", 6'h10, 32'hDEADBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadOnly();
    testBytes();
    testStatus();
    testPower();
    testCodec();
    testUnimpl();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule